// File: doc/BRIEF.md
# Serial Audio Control Register Receiver

This block is the write-only control port of a two-channel stereo sound processor. It watches a two-wire I2C bus on its own system clock, recognises start and stop conditions, and accepts transfers addressed to it. A transfer carries three bytes: the device address, a register selector and one data byte. The data byte lands in one of eight control registers.

The eight registers cover left and right volume for a loudspeaker channel and a headphone channel, bass, treble, and one switch byte per channel. The block does not pass the raw bytes on. It turns them into ready-to-use step indices and select lines. Volume, bass and treble codes saturate at the ends of their ranges. After reset both channels are muted until the loudspeaker switch byte clears the mute bit.

One bit of the device address comes from a strap input, so two such receivers can share one bus.

Top module: `audio_ctrl_rx`

## Requirements
- R1: A falling SDA while SCL is high is a start condition. It restarts reception at the address byte from any point, including in the middle of a byte. A rising SDA while SCL is high is a stop condition. It ends the transfer and releases SDA. A transfer cut short before its data byte writes nothing.
- R2: The address byte, sent MSB first, must equal {ADDR_HI[5:0], addr_sel_i, 0}. With the default ADDR_HI of 6'b100000 this is 0x80 when the strap is 0 and 0x82 when it is 1. Any other address gets no ACK and writes nothing.
- R3: An address byte with bit 0 (the read/write bit) set to 1 gets no ACK and writes nothing.
- R4: The second byte selects the register. Code 0 is loudspeaker volume left, 1 is loudspeaker volume right, 2 is bass, 3 is treble, 8 is the loudspeaker switch byte, 4 is headphone volume left, 5 is headphone volume right and 12 is the headphone switch byte. Any other code gets no ACK and writes nothing.
- R5: The receiver holds SDA low through the 9th clock after a matching address, after a valid selector and after the data byte. At all other times it leaves SDA released, and it changes its SDA drive only while SCL is low.
- R6: Only one data byte is accepted per transfer. A further byte before the stop gets no ACK and writes nothing.
- R7: After reset every register reads as zero, except that the mute bit is set (mute_o = 1).
- R8: Loudspeaker volume uses data bits 5:0 and ignores bits 7:6. The output index is code − 23 for codes 24 to 63, giving 1 = −62 dB up to 40 = +16 dB in 2 dB steps. Codes 0 to 23 give index 0, which is full attenuation.
- R9: Headphone volume uses data bits 5:0. The output index is code − 31 for codes 32 to 63, giving 1 = −62 dB up to 32 = 0 dB. Codes 0 to 31 give index 0, which is full attenuation.
- R10: Bass uses data bits 3:0 in 3 dB steps. The index is code − 2 clamped to the range 0 to 9: codes 0 to 2 give 0 (−12 dB), code 6 gives 4 (flat), and codes 11 to 15 give 9 (+15 dB).
- R11: Treble uses data bits 3:0 in 3 dB steps. The index is code − 2 clamped to the range 0 to 8: codes 0 to 2 give 0 (−12 dB), code 6 gives 4 (flat), and codes 10 to 15 give 8 (+12 dB).
- R12: Loudspeaker switch byte: bit 7 drives in_sel_o, bit 4 drives mute_o, bits 3:2 drive fx_sel_o[1:0] and bits 1:0 drive spk_mode_o. Headphone switch byte: bit 3 drives ext_sw_o and bits 2:1 drive hp_mode_o. The mode outputs carry 11 for stereo, 10 for sound A and 01 for sound B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (ACK) |
| addr_sel_i | input | 1 | Strap that sets address bit 1 |
| spk_vol_l_o | output | 6 | Loudspeaker left volume index |
| spk_vol_r_o | output | 6 | Loudspeaker right volume index |
| hp_vol_l_o | output | 6 | Headphone left volume index |
| hp_vol_r_o | output | 6 | Headphone right volume index |
| bass_o | output | 4 | Bass step index |
| treble_o | output | 4 | Treble step index |
| spk_mode_o | output | 2 | Loudspeaker sound mode |
| hp_mode_o | output | 2 | Headphone sound mode |
| in_sel_o | output | 1 | Input source select |
| fx_sel_o | output | 2 | Stereo effect select |
| ext_sw_o | output | 1 | External switch output |
| mute_o | output | 1 | Both channels muted |

## Verification
A wrong receive state or bit count shows up first on sda_oe_o. An ACK that is missing, extra or shifted appears within the 9th clock of the byte in which the state went astray. A wrong register selector or a wrong write strobe corrupts one decoded output. It appears about three system clocks after the SCL fall that closes the data byte, and it stays there until the next write to that register. Saturation errors appear only at the edge codes, so the stimulus puts codes on each side of every clamp point.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;
  localparam int NREG = 8;
  localparam int IDXW = $clog2(NREG);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_SUB, ST_DATA, ST_SKIP} rx_st_e;

  localparam logic [IDXW-1:0] RG_SPK_VL = 3'd0;
  localparam logic [IDXW-1:0] RG_SPK_VR = 3'd1;
  localparam logic [IDXW-1:0] RG_BASS   = 3'd2;
  localparam logic [IDXW-1:0] RG_TREB   = 3'd3;
  localparam logic [IDXW-1:0] RG_SPK_SW = 3'd4;
  localparam logic [IDXW-1:0] RG_HP_VL  = 3'd5;
  localparam logic [IDXW-1:0] RG_HP_VR  = 3'd6;
  localparam logic [IDXW-1:0] RG_HP_SW  = 3'd7;

  typedef struct packed {
    logic            valid;
    logic [IDXW-1:0] idx;
  } sub_hit_t;

  function automatic sub_hit_t sub_lookup(input logic [7:0] code);
    sub_hit_t h;
    h.valid = 1'b1;
    case (code)
      8'd0:    h.idx = RG_SPK_VL;
      8'd1:    h.idx = RG_SPK_VR;
      8'd2:    h.idx = RG_BASS;
      8'd3:    h.idx = RG_TREB;
      8'd8:    h.idx = RG_SPK_SW;
      8'd4:    h.idx = RG_HP_VL;
      8'd5:    h.idx = RG_HP_VR;
      8'd12:   h.idx = RG_HP_SW;
      default: begin h.valid = 1'b0; h.idx = '0; end
    endcase
    return h;
  endfunction
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_p  <= scl_ff[STAGES-1];
      sda_p  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/rx_fsm.sv
module rx_fsm
  import audio_rx_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [6:0]      dev_addr_i,
  input  logic            sda_s_i,
  input  logic            scl_rise_i,
  input  logic            scl_fall_i,
  input  logic            start_i,
  input  logic            stop_i,
  output logic            sda_oe_o,
  output logic [NREG-1:0] wr_en_o,
  output logic [7:0]      wr_data_o
);
  rx_st_e          state, nxt;
  logic [3:0]      cnt;
  logic [7:0]      shreg;
  logic            ack_ph;
  logic [IDXW-1:0] sub_idx;
  sub_hit_t        hit;
  logic            byte_done;

  assign hit       = sub_lookup(shreg);
  assign byte_done = scl_fall_i && (cnt == 4'd8) && !ack_ph && !start_i && !stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      nxt      <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      ack_ph   <= 1'b0;
      sub_idx  <= '0;
      sda_oe_o <= 1'b0;
    end else if (start_i) begin
      state    <= ST_ADDR;
      cnt      <= '0;
      ack_ph   <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (stop_i) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      ack_ph   <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (state == ST_ADDR || state == ST_SUB || state == ST_DATA) begin
      if (scl_rise_i && !ack_ph && cnt < 4'd8) begin
        shreg <= {shreg[6:0], sda_s_i};
        cnt   <= cnt + 4'd1;
      end else if (scl_fall_i && ack_ph) begin
        sda_oe_o <= 1'b0;
        ack_ph   <= 1'b0;
        cnt      <= '0;
        state    <= nxt;
      end else if (byte_done) begin
        unique case (state)
          ST_ADDR: begin
            if (shreg == {dev_addr_i, 1'b0}) begin
              sda_oe_o <= 1'b1;
              ack_ph   <= 1'b1;
              nxt      <= ST_SUB;
            end else begin
              state <= ST_SKIP;
            end
          end
          ST_SUB: begin
            if (hit.valid) begin
              sub_idx  <= hit.idx;
              sda_oe_o <= 1'b1;
              ack_ph   <= 1'b1;
              nxt      <= ST_DATA;
            end else begin
              state <= ST_SKIP;
            end
          end
          default: begin
            sda_oe_o <= 1'b1;
            ack_ph   <= 1'b1;
            nxt      <= ST_SKIP;
          end
        endcase
      end
    end
  end

  always_comb begin
    wr_en_o = '0;
    if (byte_done && state == ST_DATA) wr_en_o[sub_idx] = 1'b1;
  end
  assign wr_data_o = shreg;
endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
  import audio_rx_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NREG-1:0]      wr_en_i,
  input  logic [7:0]           wr_data_i,
  output logic [NREG-1:0][7:0] regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] RST = (g == int'(RG_SPK_SW)) ? 8'h10 : 8'h00;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         regs_o[g] <= RST;
      else if (wr_en_i[g]) regs_o[g] <= wr_data_i;
    end
  end
endmodule

// File: rtl/step_map.sv
module step_map #(
  parameter int W  = 6,
  parameter int LO = 24,
  parameter int HI = 63
) (
  input  logic [W-1:0] code_i,
  output logic [W-1:0] idx_o
);
  localparam logic [W-1:0] LO_V = W'(LO);
  localparam logic [W-1:0] HI_V = W'(HI);
  always_comb begin
    if (code_i < LO_V)      idx_o = '0;
    else if (code_i > HI_V) idx_o = HI_V - LO_V;
    else                    idx_o = code_i - LO_V;
  end
endmodule

// File: rtl/audio_ctrl_rx.sv
module audio_ctrl_rx
  import audio_rx_pkg::*;
#(
  parameter logic [5:0] ADDR_HI     = 6'b100000,
  parameter int         SYNC_STAGES = 2,
  parameter int         SPK_FLOOR   = 24,
  parameter int         HP_FLOOR    = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       addr_sel_i,
  output logic [5:0] spk_vol_l_o,
  output logic [5:0] spk_vol_r_o,
  output logic [5:0] hp_vol_l_o,
  output logic [5:0] hp_vol_r_o,
  output logic [3:0] bass_o,
  output logic [3:0] treble_o,
  output logic [1:0] spk_mode_o,
  output logic [1:0] hp_mode_o,
  output logic       in_sel_o,
  output logic [1:0] fx_sel_o,
  output logic       ext_sw_o,
  output logic       mute_o
);
  localparam int NVOL = 4;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [NREG-1:0]      wr_en;
  logic [7:0]           wr_data;
  logic [NREG-1:0][7:0] regs;
  logic [NVOL-1:0][5:0] vol_idx;

  bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  rx_fsm u_fsm (
    .clk_i, .rst_ni,
    .dev_addr_i({ADDR_HI, addr_sel_i}),
    .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .sda_oe_o, .wr_en_o(wr_en), .wr_data_o(wr_data)
  );

  ctrl_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_data_i(wr_data), .regs_o(regs)
  );

  // offset by one so that index 0 stays reserved for full attenuation
  for (genvar g = 0; g < NVOL; g++) begin : g_vol
    localparam logic [IDXW-1:0] RI = (g == 0) ? RG_SPK_VL : (g == 1) ? RG_SPK_VR :
                                     (g == 2) ? RG_HP_VL  : RG_HP_VR;
    localparam int FL = (g < 2) ? SPK_FLOOR : HP_FLOOR;
    logic [5:0] raw;
    step_map #(.W(6), .LO(FL - 1), .HI(63)) u_map (
      .code_i((regs[RI][5:0] < 6'(FL)) ? 6'(FL - 1) : regs[RI][5:0]),
      .idx_o (raw)
    );
    assign vol_idx[g] = raw;
  end

  step_map #(.W(4), .LO(2), .HI(11)) u_bass (.code_i(regs[RG_BASS][3:0]), .idx_o(bass_o));
  step_map #(.W(4), .LO(2), .HI(10)) u_treb (.code_i(regs[RG_TREB][3:0]), .idx_o(treble_o));

  assign spk_vol_l_o = vol_idx[0];
  assign spk_vol_r_o = vol_idx[1];
  assign hp_vol_l_o  = vol_idx[2];
  assign hp_vol_r_o  = vol_idx[3];
  assign in_sel_o    = regs[RG_SPK_SW][7];
  assign mute_o      = regs[RG_SPK_SW][4];
  assign fx_sel_o    = regs[RG_SPK_SW][3:2];
  assign spk_mode_o  = regs[RG_SPK_SW][1:0];
  assign ext_sw_o    = regs[RG_HP_SW][3];
  assign hp_mode_o   = regs[RG_HP_SW][2:1];
endmodule

// File: rtl/audio_ctrl_rx_chk.sv
module audio_ctrl_rx_chk
  import audio_rx_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            scl_s,
  input logic            stop_det,
  input logic            sda_oe_o,
  input logic [NREG-1:0] wr_en,
  input logic            mute_o,
  input logic [5:0]      spk_vol_l_o,
  input logic [5:0]      hp_vol_l_o,
  input logic [3:0]      bass_o,
  input logic [3:0]      treble_o
);
  assert_ack_scl_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s);
  assert_data_acked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_en) |=> sda_oe_o);
  assert_one_target_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en));
  assert_stop_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);
  assert_mute_by_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mute_o) |-> $past(wr_en[RG_SPK_SW]));
  assert_spk_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spk_vol_l_o <= 6'd40);
  assert_hp_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hp_vol_l_o <= 6'd32);
  assert_bass_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bass_o <= 4'd9);
  assert_treble_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    treble_o <= 4'd8);
endmodule

bind audio_ctrl_rx audio_ctrl_rx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .stop_det(stop_det),
  .sda_oe_o(sda_oe_o), .wr_en(wr_en), .mute_o(mute_o),
  .spk_vol_l_o(spk_vol_l_o), .hp_vol_l_o(hp_vol_l_o),
  .bass_o(bass_o), .treble_o(treble_o)
);

// File: tb/audio_ctrl_rx_bench.sv
module audio_ctrl_rx_bench;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic hold = 1'b1, done = 1'b0;
  int   checks = 0, failures = 0;
  logic [7:0] m_reg [16];

  logic sda_oe, in_sel, ext_sw, mute;
  logic [5:0] svl, svr, hvl, hvr;
  logic [3:0] bass, treb;
  logic [1:0] smode, hmode, fx;
  wire  sda_bus = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  audio_ctrl_rx u_audio_ctrl_rx (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .addr_sel_i(strap), .spk_vol_l_o(svl), .spk_vol_r_o(svr), .hp_vol_l_o(hvl),
    .hp_vol_r_o(hvr), .bass_o(bass), .treble_o(treb), .spk_mode_o(smode),
    .hp_mode_o(hmode), .in_sel_o(in_sel), .fx_sel_o(fx), .ext_sw_o(ext_sw), .mute_o(mute)
  );

  function automatic int spk_idx(input logic [7:0] c);
    int v = int'(c[5:0]);
    return (v < 24) ? 0 : v - 23;
  endfunction
  function automatic int hp_idx(input logic [7:0] c);
    int v = int'(c[5:0]);
    return (v < 32) ? 0 : v - 31;
  endfunction
  function automatic int clamp_idx(input logic [7:0] c, input int top);
    int v = int'(c[3:0]) - 2;
    if (v < 0) v = 0;
    if (v > top) v = top;
    return v;
  endfunction
  function automatic bit sub_ok(input logic [7:0] s);
    return s == 0 || s == 1 || s == 2 || s == 3 || s == 4 || s == 5 || s == 8 || s == 12;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !hold && !done) begin
      chk("R8 spk_vol_l", svl, spk_idx(m_reg[0]));
      chk("R8 spk_vol_r", svr, spk_idx(m_reg[1]));
      chk("R9 hp_vol_l", hvl, hp_idx(m_reg[4]));
      chk("R9 hp_vol_r", hvr, hp_idx(m_reg[5]));
      chk("R10 bass", bass, clamp_idx(m_reg[2], 9));
      chk("R11 treble", treb, clamp_idx(m_reg[3], 8));
      chk("R12 in_sel", in_sel, m_reg[8][7]);
      chk("R7 mute", mute, m_reg[8][4]);
      chk("R12 fx_sel", fx, m_reg[8][3:2]);
      chk("R12 spk_mode", smode, m_reg[8][1:0]);
      chk("R12 ext_sw", ext_sw, m_reg[12][3]);
      chk("R12 hp_mode", hmode, m_reg[12][2:1]);
      chk("R5 sda idle", sda_oe, 0);
    end
  end

  task automatic wait_q(input int n);
    repeat (n * Q) @(negedge clk);
  endtask
  task automatic bit_out(input logic b);
    sda_m = b; wait_q(1); scl_m = 1'b1; wait_q(2); scl_m = 1'b0; wait_q(1);
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    sda_m = 1'b1; wait_q(1); scl_m = 1'b1; wait_q(1);
    ack = sda_oe; wait_q(1); scl_m = 1'b0; wait_q(1);
  endtask
  task automatic do_start;
    sda_m = 1'b1; wait_q(1); scl_m = 1'b1; wait_q(2); sda_m = 1'b0; wait_q(2);
    scl_m = 1'b0; wait_q(1);
  endtask
  task automatic do_stop;
    sda_m = 1'b0; wait_q(1); scl_m = 1'b1; wait_q(2); sda_m = 1'b1; wait_q(2);
  endtask

  function automatic logic [7:0] my_addr(input logic rw);
    return {6'b100000, strap, rw};
  endfunction

  // address, selector, data, optional extra byte; ACK expectations follow the requirements
  task automatic xfer(input logic [7:0] a, input logic [7:0] s, input logic [7:0] d,
                      input bit extra, input string tag);
    logic ack;
    bit a_ok, s_ok;
    hold = 1'b1;
    a_ok = (a == my_addr(1'b0));
    s_ok = a_ok && sub_ok(s);
    do_start;
    send_byte(a, ack); chk({tag, " addr ack"}, ack, a_ok);
    send_byte(s, ack); chk({tag, " sub ack"}, ack, s_ok);
    send_byte(d, ack); chk({tag, " data ack"}, ack, s_ok);
    if (s_ok) m_reg[s[3:0]] = d;
    if (extra) begin
      send_byte(8'hA5, ack); chk({tag, " R6 extra ack"}, ack, 0);
    end
    do_stop;
    wait_q(2);
    hold = 1'b0;
  endtask

  initial begin
    logic ack;
    foreach (m_reg[i]) m_reg[i] = 8'h00;
    m_reg[8] = 8'h10;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 mute after reset", mute, 1);
    hold = 1'b0;
    wait_q(2);

    xfer(8'h80, 8'd0, 8'd63, 0, "R8 max");
    xfer(8'h80, 8'd1, 8'd24, 0, "R8 floor");
    xfer(8'h80, 8'd0, 8'd23, 0, "R8 below floor");
    xfer(8'h80, 8'd1, 8'hFF, 0, "R8 high bits");
    xfer(8'h80, 8'd4, 8'd63, 0, "R9 max");
    xfer(8'h80, 8'd5, 8'd32, 0, "R9 floor");
    xfer(8'h80, 8'd4, 8'd31, 0, "R9 below floor");
    xfer(8'h80, 8'd2, 8'd15, 0, "R10 top");
    xfer(8'h80, 8'd2, 8'd11, 0, "R10 knee");
    xfer(8'h80, 8'd2, 8'd6,  0, "R10 flat");
    xfer(8'h80, 8'd2, 8'd1,  0, "R10 bottom");
    xfer(8'h80, 8'd3, 8'd15, 0, "R11 top");
    xfer(8'h80, 8'd3, 8'd10, 0, "R11 knee");
    xfer(8'h80, 8'd3, 8'd9,  0, "R11 below knee");
    xfer(8'h80, 8'd3, 8'd2,  0, "R11 bottom");
    xfer(8'h80, 8'd8, 8'h83, 0, "R12 spk switch");
    xfer(8'h80, 8'd12, 8'h0A, 0, "R12 hp switch");
    xfer(8'h80, 8'd8, 8'h1E, 0, "R12 remute");
    xfer(8'h80, 8'd6, 8'h3F, 0, "R4 bad sel 6");
    xfer(8'h80, 8'd9, 8'h3F, 0, "R4 bad sel 9");
    xfer(8'h80, 8'd16, 8'h3F, 0, "R4 bad sel 16");
    xfer(8'h82, 8'd0, 8'd40, 0, "R2 wrong strap addr");
    xfer(8'h81, 8'd0, 8'd40, 0, "R3 read bit");
    xfer(8'h80, 8'd5, 8'd50, 1, "R6 extra byte");
    strap = 1'b1;
    wait_q(2);
    xfer(8'h82, 8'd1, 8'd44, 0, "R2 strap high");
    xfer(8'h80, 8'd1, 8'd30, 0, "R2 strap high old addr");

    // R1: restart inside the data byte, then a full transfer
    hold = 1'b1;
    do_start;
    send_byte(8'h82, ack); chk("R1 addr ack", ack, 1);
    send_byte(8'd0, ack);  chk("R1 sub ack", ack, 1);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    do_start;
    send_byte(8'h82, ack); chk("R1 restart addr ack", ack, 1);
    send_byte(8'd1, ack);  chk("R1 restart sub ack", ack, 1);
    send_byte(8'd48, ack); chk("R1 restart data ack", ack, 1);
    m_reg[1] = 8'd48;
    do_stop;
    // R1: stop after the selector leaves the register untouched
    do_start;
    send_byte(8'h82, ack); chk("R1 short addr ack", ack, 1);
    send_byte(8'd0, ack);  chk("R1 short sub ack", ack, 1);
    do_stop;
    wait_q(2);
    hold = 1'b0;
    wait_q(4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule